// File: doc/BRIEF.md
# Serial Video Word Scrambler and NRZI Line Encoder

This block turns a stream of 10-bit parallel video words into one serial line bit per bit-clock cycle. A word is presented together with a one-cycle strobe on the bit clock, and the block captures it into a holding register. It then sends the word on the line least significant bit first, ten bits per word. Each serial bit passes through a self-synchronising scrambler built on the generator x^9 + x^4 + 1. The scrambled bit then drives an NRZI stage (x + 1) that flips the line level on every scrambled 1.

The bit clock runs at exactly ten times the word rate and comes from outside the block. A lock input gates the whole datapath. While lock is low, no register advances and the line level stays where it is. An active-low asynchronous reset clears every register, the scrambler history included, and holds the line output enable low so that the pad driver stays in high impedance.

Top module: `sd_serial_tx`

## Requirements
- R1: While `rst_n` is low, `sdo` is 0 and `sdo_oe` is 0. All state is cleared, so the first ten serialised data bits after reset are zeros, and the scrambler history starts at zero.
- R2: `word_in` is captured on any bit-clock edge where `word_strobe` is 1, whatever the value of `lock_ok`. The captured word moves into the serialiser on the edge that ends the tenth bit of the word in flight, and its bits go out in the following ten active cycles.
- R3: On each active cycle the `sdo` level after the edge equals the level before the edge XOR the scrambled bit. A scrambled 1 toggles the line and a scrambled 0 holds it.
- R4: The bits of each word are serialised least significant bit first: bit 0, then bit 1, up to bit 9.
- R5: Exactly ten active bit-clock cycles are spent on each word, one serial bit per cycle.
- R6: On a bit-clock edge where `lock_ok` is 0, the serialiser, the scrambler history and `sdo` all keep their values.
- R7: `sdo_oe` goes to 1 on the first bit-clock edge after `rst_n` is released and stays at 1 until the next reset.
- R8: The scrambled bit for serial bit k equals data bit k XOR scrambled bit k-4 XOR scrambled bit k-9, with scrambled bits from before the last reset taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock, ten times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_strobe | input | 1 | Marks the cycle in which `word_in` holds a new word |
| word_in | input | 10 | Parallel video word |
| lock_ok | input | 1 | Clock lock indication; low freezes the datapath |
| sdo | output | 1 | Serial NRZI line level |
| sdo_oe | output | 1 | Output enable for the line driver; low means high impedance |

## Verification
The bench sends all-zero, all-one and single-bit words, so a wrong bit order or an off-by-one in the word counter shows up as a wrong toggle pattern within a few bits. Long runs of ones and zeros reach both scrambler taps; a wrong tap index corrupts the line only after four or nine bits, and the bench follows the stream far enough to see it. Lock is dropped in the middle of a word and a strobe is given while unlocked. A design that let the counter or scrambler advance in that window, or that dropped the captured word, would lose alignment for every later bit. A reset in mid-run then checks that no scrambler history survives and that the first word after reset is preceded by ten zero bits.

// File: rtl/sd_tx_pkg.sv
package sd_tx_pkg;

  // Word and scrambler geometry
  parameter int WORD_BITS = 10;
  parameter int SCR_LEN   = 9;
  parameter int SCR_TAP   = 4;

  // Scrambled bit from the data bit and the two delayed scrambled bits
  function automatic logic scr_next(input logic data_bit,
                                    input logic tap_short,
                                    input logic tap_long);
    return data_bit ^ tap_short ^ tap_long;
  endfunction

  // NRZI: a 1 flips the line, a 0 leaves it
  function automatic logic nrzi_next(input logic level,
                                     input logic code_bit);
    return level ^ code_bit;
  endfunction

endpackage

// File: rtl/sd_tx_word_shifter.sv
module sd_tx_word_shifter
  import sd_tx_pkg::*;
#(
  parameter int WORD_W = WORD_BITS
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_bit
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_bit;
  logic              load_evt;

  assign last_bit = (cnt_q == LAST_IDX);
  assign load_evt = adv && last_bit;
  assign ser_bit  = sh_q[0];

  // Capture register: independent of lock
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (strobe) hold_q <= word_in;
  end

  // Bit counter and LSB-first shift register
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (load_evt) begin
      cnt_q <= '0;
      sh_q  <= hold_q;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
    end
  end

  // R5
  wrap_after_tenth_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    load_evt |=> (cnt_q == '0));

  // R4
  lsb_first_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (adv && !last_bit) |=> (ser_bit == $past(sh_q[1])));

  // R6
  shifter_frozen_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !adv |=> ($stable(cnt_q) && $stable(sh_q)));

endmodule

// File: rtl/sd_tx_scrambler.sv
module sd_tx_scrambler
  import sd_tx_pkg::*;
#(
  parameter int LEN = SCR_LEN,
  parameter int TAP = SCR_TAP
) (
  input  logic clk_bit,
  input  logic rst_n,
  input  logic adv,
  input  logic data_bit,
  output logic scr_bit
);

  // st_q[0] is the scrambled bit one cycle back, st_q[i] is i+1 back
  logic [LEN-1:0] st_q;

  assign scr_bit = scr_next(data_bit, st_q[TAP-1], st_q[LEN-1]);

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n)   st_q <= '0;
    else if (adv) st_q <= {st_q[LEN-2:0], scr_bit};
  end

  // R8
  feedback_shift_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    adv |=> (st_q[0] == $past(scr_bit)));

  // R6
  scrambler_frozen_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !adv |=> $stable(st_q));

endmodule

// File: rtl/sd_tx_nrzi.sv
module sd_tx_nrzi
  import sd_tx_pkg::*;
(
  input  logic clk_bit,
  input  logic rst_n,
  input  logic adv,
  input  logic code_bit,
  output logic line,
  output logic line_oe
);

  logic level_q;
  logic oe_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= 1'b1;
      if (adv) level_q <= nrzi_next(level_q, code_bit);
    end
  end

  assign line    = level_q;
  assign line_oe = oe_q;

  // R3
  toggle_on_one_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    adv |=> ((line != $past(line)) == $past(code_bit)));

endmodule

// File: rtl/sd_serial_tx.sv
module sd_serial_tx
  import sd_tx_pkg::*;
(
  input  logic                 clk_bit,
  input  logic                 rst_n,
  input  logic                 word_strobe,
  input  logic [WORD_BITS-1:0] word_in,
  input  logic                 lock_ok,
  output logic                 sdo,
  output logic                 sdo_oe
);

  logic data_bit;
  logic scr_bit;

  sd_tx_word_shifter #(.WORD_W(WORD_BITS)) u_shift (
    .clk_bit (clk_bit),
    .rst_n   (rst_n),
    .adv     (lock_ok),
    .strobe  (word_strobe),
    .word_in (word_in),
    .ser_bit (data_bit)
  );

  sd_tx_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .adv      (lock_ok),
    .data_bit (data_bit),
    .scr_bit  (scr_bit)
  );

  sd_tx_nrzi u_nrzi (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .adv      (lock_ok),
    .code_bit (scr_bit),
    .line     (sdo),
    .line_oe  (sdo_oe)
  );

  // R6
  line_static_unlocked_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !lock_ok |=> $stable(sdo));

  // R7
  enable_after_reset_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    rst_n |=> sdo_oe);

endmodule

// File: tb/sd_serial_tx_test.sv
module sd_serial_tx_test;

  logic       clk_bit = 1'b0;
  logic       rst_n;
  logic       word_strobe;
  logic [9:0] word_in;
  logic       lock_ok;
  logic       sdo;
  logic       sdo_oe;

  always #2 clk_bit = ~clk_bit;  // 250 MHz

  sd_serial_tx uut (
    .clk_bit     (clk_bit),
    .rst_n       (rst_n),
    .word_strobe (word_strobe),
    .word_in     (word_in),
    .lock_ok     (lock_ok),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  typedef struct {
    logic  lvl;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference model state, kept as a full log of scrambled bits
  bit         scr_log[$];
  logic       m_level;
  logic [9:0] m_cur;
  logic [9:0] m_hold;
  int         m_pos;

  function automatic bit delayed(input int back);
    if (scr_log.size() < back) return 1'b0;
    return scr_log[scr_log.size() - back];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic model_clear();
    scr_log.delete();
    m_level = 1'b0;
    m_cur   = '0;
    m_hold  = '0;
    m_pos   = 0;
  endtask

  // Driver: one bit-clock cycle of stimulus, expectation pushed to the scoreboard
  task automatic cycle(input bit lk, input bit stb, input logic [9:0] w, input string tag);
    bit d;
    bit s;
    @(negedge clk_bit);
    lock_ok     = lk;
    word_strobe = stb;
    word_in     = w;
    if (lk) begin
      d = m_cur[m_pos];                         // R4: LSB first
      s = d ^ delayed(4) ^ delayed(9);          // R8
      scr_log.push_back(s);
      if (s) m_level = ~m_level;                // R3
      m_pos++;
      if (m_pos == 10) begin                    // R5
        m_pos = 0;
        m_cur = m_hold;                         // R2
      end
    end
    if (stb) m_hold = w;                        // R2: captured regardless of lock
    exp_q.push_back('{m_level, tag});
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++)
      cycle(1'b1, i == 0, w, "R2 R3 R4 R5 R8 stream");
  endtask

  task automatic do_reset();
    @(negedge clk_bit);
    lock_ok     = 1'b0;
    word_strobe = 1'b0;
    word_in     = '0;
    rst_n       = 1'b0;
    #1;
    check(sdo === 1'b0, "R1 sdo in reset", int'(sdo), 0);
    check(sdo_oe === 1'b0, "R1 sdo_oe in reset", int'(sdo_oe), 0);
    repeat (3) @(negedge clk_bit);
    check(sdo_oe === 1'b0, "R1 sdo_oe held in reset", int'(sdo_oe), 0);
    model_clear();
    rst_n = 1'b1;
    @(posedge clk_bit);
    #1;
    check(sdo_oe === 1'b1, "R7 enable after release", int'(sdo_oe), 1);
    check(sdo === 1'b0, "R1 line after release", int'(sdo), 0);
  endtask

  // Monitor: compares the line one step after each active edge
  initial begin
    forever begin
      @(posedge clk_bit);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(sdo === e.lvl, e.tag, int'(sdo), int'(e.lvl));
        check(sdo_oe === 1'b1, "R7 enable held", int'(sdo_oe), 1);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk_bit);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog: actual %0d cycles expected fewer", 100000);
    finish_run();
  end

  logic [9:0] pattern [8];
  logic       before_unlock;

  initial begin
    rst_n       = 1'b0;
    lock_ok     = 1'b0;
    word_strobe = 1'b0;
    word_in     = '0;
    model_clear();

    do_reset();

    pattern[0] = 10'h000;
    pattern[1] = 10'h3FF;
    pattern[2] = 10'h001;
    pattern[3] = 10'h200;
    pattern[4] = 10'h155;
    pattern[5] = 10'h2AA;
    pattern[6] = 10'h3FF;
    pattern[7] = 10'h0F3;
    for (int i = 0; i < 8; i++) send_word(pattern[i]);
    send_word(10'h000);

    // R6: lock lost mid-word, with a strobe inside the unlocked window (R2)
    for (int i = 0; i < 4; i++) cycle(1'b1, i == 0, 10'h3C5, "R4 R8 pre-unlock");
    @(posedge clk_bit);
    #1;
    before_unlock = sdo;
    for (int i = 0; i < 6; i++) cycle(1'b0, i == 2, 10'h19B, "R6 held while unlocked");
    @(posedge clk_bit);
    #1;
    check(sdo === before_unlock, "R6 line static across unlock", int'(sdo), int'(before_unlock));
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 10'h000, "R2 R5 resume after unlock");
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0, 10'h000, "R2 word from unlocked strobe");
    send_word(10'h3FF);
    send_word(10'h000);
    send_word(10'h000);

    // Mid-run reset: no history survives, first ten bits are zeros (R1)
    do_reset();
    for (int i = 0; i < 10; i++) cycle(1'b1, i == 0, 10'h3FF, "R1 zero bits after reset");
    @(posedge clk_bit);
    #1;
    check(sdo === 1'b0, "R1 quiet first word after reset", int'(sdo), 0);
    send_word(10'h001);
    send_word(10'h3FE);
    send_word(10'h000);

    @(posedge clk_bit);
    #1;
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule